// File: doc/BRIEF.md
# Register-Mapped AXI4-Lite Single-Beat Bridge

This block lets a host with a narrow 16-bit register port run single 32-bit accesses on an AXI4-Lite master port. The host loads a 32-bit target address and, for writes, a 32-bit data word, each as two 16-bit halves. It clears any stale events and then writes a command code into the control register. The bridge runs exactly one AXI transaction. It ends the transaction with one of four outcomes (read done, write done, error or timeout) and records it as a sticky event in the status register. A successful read returns its word as two 16-bit halves.

The control register holds a command field and five event enables. The interrupt output is raised while any enabled sticky event is set. Two post-increment command codes step the stored address by one word after a successful transfer, so the host can walk a block of consecutive words without reloading the address. A level input from the AXI side sets a fifth sticky event. An initialisation-done flag rises a fixed number of cycles after reset is released.

Top module: `axi_reg_bridge`

## Requirements
- R1: The register window has eight 16-bit registers at these offsets: 0 status, 1 control, 2 address bits 15:0, 3 address bits 31:16, 4 write data bits 15:0, 5 write data bits 31:16, 6 read data bits 15:0, 7 read data bits 31:16. The address and write data halves read back the value last written.
- R2: The command field is control bits 3:0. The codes are 0x8 write, 0x9 write with post-increment, 0xA read and 0xB read with post-increment. Code 0x0 and every other code start nothing and leave busy low.
- R3: Status bit 6 (busy) rises on the edge that accepts a command and falls on the edge that records the outcome. A command written while busy is high is ignored.
- R4: Each transfer sets exactly one of these status bits: 15 read done, 14 write done, 13 timeout, 12 error. A successful read stores the AXI word in offsets 6 and 7 and sets status bit 7 (read data available). Bit 7 clears when the next command is accepted.
- R5: A write drives the AXI address from offsets 3:2 and the AXI data from offsets 5:4, with all four byte strobes set. Address and data stay stable until their handshakes complete.
- R6: An AXI response of SLVERR or DECERR (response bit 1 set) sets the error event instead of the done event.
- R7: If no handshake completes for TIMEOUT_CYCLES consecutive cycles, the bridge drops every valid and ready, returns to idle and sets the timeout event.
- R8: After a successful transfer, codes 0x9 and 0xB add 4 to the 32-bit stored address, with the carry passing from offset 2 into offset 3. After an error or a timeout the address is left unchanged.
- R9: Status bits 15:11 are sticky and are cleared by writing 1 to them. Writing 0 leaves them set. Bits 7, 6 and 5 reflect live state and ignore writes.
- R10: Control bits 15:11 enable status bits 15:11 one for one. The irq output is high while any set event has its enable set.
- R11: Status bit 5 (initialisation done) is low just after reset and is high from INIT_CYCLES cycles after reset release onward.
- R12: While the ext_irq input is high, status bit 11 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr (combinational) |
| irq | output | 1 | Interrupt, OR of enabled sticky events |
| ext_irq | input | 1 | Interrupt level from the AXI side |
| m_awaddr | output | 32 | AXI write address |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | AXI write strobes |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_bresp | input | 2 | AXI write response |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |
| m_araddr | output | 32 | AXI read address |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |

## Verification
The hardest situation to reach is a command written while a transfer is still pending. A normal slave finishes in a few cycles, which leaves almost no window for a second host write. The bench therefore switches its slave model to a silent mode that never raises ready. It issues a write command, then a read command a few cycles later, and lets the full timeout elapse. It then confirms that only the timeout event is set, that busy is low and that no read address was ever presented. The carry of the post-increment from the low address half into the high half is reached with a directed address of 0x0000FFFC.

// File: rtl/axib_pkg.sv
package axib_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int EV_W   = 5;

    // event vector index, mapped onto status bits 15:11
    localparam int EV_RD  = 4;
    localparam int EV_WR  = 3;
    localparam int EV_TMO = 2;
    localparam int EV_ERR = 1;
    localparam int EV_IRQ = 0;

    typedef enum logic [2:0] {
        OFF_STAT    = 3'd0,
        OFF_CTRL    = 3'd1,
        OFF_ADDR_LO = 3'd2,
        OFF_ADDR_HI = 3'd3,
        OFF_WDAT_LO = 3'd4,
        OFF_WDAT_HI = 3'd5,
        OFF_RDAT_LO = 3'd6,
        OFF_RDAT_HI = 3'd7
    } reg_off_e;

    typedef enum logic [1:0] {
        END_RD_OK,
        END_WR_OK,
        END_ERR,
        END_TMO
    } end_kind_e;

    typedef struct packed {
        logic              is_read;
        logic              post_inc;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } xfer_req_t;

    typedef struct packed {
        logic              valid;
        end_kind_e         kind;
        logic [WORD_W-1:0] rdata;
    } xfer_end_t;

    // codes 0x8..0xB start a transfer; bit 1 selects read, bit 0 post-increment
    function automatic logic cmd_starts(input logic [3:0] code);
        return code[3:2] == 2'b10;
    endfunction

    function automatic logic resp_is_error(input logic [1:0] resp);
        return resp[1];
    endfunction
endpackage

// File: rtl/axib_regs.sv
module axib_regs
    import axib_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [HALF_W-1:0] host_wdata,
    output logic [HALF_W-1:0] host_rdata,
    input  xfer_end_t         fin,
    input  logic              ext_irq,
    output logic              start,
    output xfer_req_t         req,
    output logic              busy,
    output logic              irq
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    logic [EV_W-1:0]   ev_q, en_q, ev_set, ev_clr;
    logic [WORD_W-1:0] addr_q, wdat_q, rdat_q;
    logic              rd_avail_q, inc_q, init_q, ok_end;
    logic [INIT_W-1:0] init_cnt;
    reg_off_e          off;

    assign off = reg_off_e'(host_addr);

    always_comb begin
        ev_set          = '0;
        ev_set[EV_IRQ]  = ext_irq;
        if (fin.valid) begin
            case (fin.kind)
                END_RD_OK: ev_set[EV_RD]  = 1'b1;
                END_WR_OK: ev_set[EV_WR]  = 1'b1;
                END_ERR:   ev_set[EV_ERR] = 1'b1;
                default:   ev_set[EV_TMO] = 1'b1;
            endcase
        end
    end

    assign ev_clr = (host_we && off == OFF_STAT) ? host_wdata[15:11] : '0;
    assign start  = host_we && off == OFF_CTRL && cmd_starts(host_wdata[3:0]) && !busy;
    assign ok_end = fin.valid && (fin.kind == END_RD_OK || fin.kind == END_WR_OK);

    assign req.is_read  = host_wdata[1];
    assign req.post_inc = host_wdata[0];
    assign req.addr     = addr_q;
    assign req.wdata    = wdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q       <= '0;
            en_q       <= '0;
            addr_q     <= '0;
            wdat_q     <= '0;
            rdat_q     <= '0;
            rd_avail_q <= 1'b0;
            inc_q      <= 1'b0;
            busy       <= 1'b0;
            init_q     <= 1'b0;
            init_cnt   <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            ev_q <= (ev_q & ~ev_clr) | ev_set;

            if (!init_q) begin
                if (init_cnt == INIT_W'(INIT_CYCLES - 1)) init_q <= 1'b1;
                else                                      init_cnt <= init_cnt + 1'b1;
            end

            if (start) begin
                busy       <= 1'b1;
                inc_q      <= host_wdata[0];
                rd_avail_q <= 1'b0;
            end else if (fin.valid) begin
                busy <= 1'b0;
            end

            if (fin.valid && fin.kind == END_RD_OK) begin
                rdat_q     <= fin.rdata;
                rd_avail_q <= 1'b1;
            end

            if (ok_end && inc_q) addr_q <= addr_q + WORD_W'(4);

            // host writes are placed last so they override the increment
            if (host_we) begin
                case (off)
                    OFF_CTRL:    en_q          <= host_wdata[15:11];
                    OFF_ADDR_LO: addr_q[15:0]  <= host_wdata;
                    OFF_ADDR_HI: addr_q[31:16] <= host_wdata;
                    OFF_WDAT_LO: wdat_q[15:0]  <= host_wdata;
                    OFF_WDAT_HI: wdat_q[31:16] <= host_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (off)
            OFF_STAT:    host_rdata = {ev_q, 3'b000, rd_avail_q, busy, init_q, 5'b00000};
            OFF_CTRL:    host_rdata = {en_q, 11'd0};
            OFF_ADDR_LO: host_rdata = addr_q[15:0];
            OFF_ADDR_HI: host_rdata = addr_q[31:16];
            OFF_WDAT_LO: host_rdata = wdat_q[15:0];
            OFF_WDAT_HI: host_rdata = wdat_q[31:16];
            OFF_RDAT_LO: host_rdata = rdat_q[15:0];
            default:     host_rdata = rdat_q[31:16];
        endcase
    end

    assign irq = |(ev_q & en_q);
endmodule

// File: rtl/axib_master.sv
module axib_master
    import axib_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req,
    output xfer_end_t         fin,
    output logic              tmo,
    output logic [WORD_W-1:0] awaddr,
    output logic              awvalid,
    input  logic              awready,
    output logic [WORD_W-1:0] wdata,
    output logic [3:0]        wstrb,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output logic [WORD_W-1:0] araddr,
    output logic              arvalid,
    input  logic              arready,
    input  logic [WORD_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rvalid,
    output logic              rready
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

    typedef enum logic [2:0] {S_IDLE, S_WADDR, S_WRESP, S_RADDR, S_RDATA} state_e;

    state_e            state;
    logic [WORD_W-1:0] addr_q, wdata_q;
    logic              aw_done, w_done, aw_hs, w_hs, hs;
    logic [CNT_W-1:0]  cnt;

    assign awvalid = state == S_WADDR && !aw_done;
    assign wvalid  = state == S_WADDR && !w_done;
    assign bready  = state == S_WRESP;
    assign arvalid = state == S_RADDR;
    assign rready  = state == S_RDATA;
    assign awaddr  = addr_q;
    assign araddr  = addr_q;
    assign wdata   = wdata_q;
    assign wstrb   = 4'hF;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;
    assign hs    = aw_hs || w_hs || (bvalid && bready) || (arvalid && arready) || (rvalid && rready);
    assign tmo   = state != S_IDLE && !hs && cnt == CNT_W'(TIMEOUT_CYCLES - 1);

    always_comb begin
        fin.valid = tmo || (state == S_WRESP && bvalid) || (state == S_RDATA && rvalid);
        fin.rdata = rdata;
        if (tmo)                                          fin.kind = END_TMO;
        else if (state == S_WRESP && resp_is_error(bresp)) fin.kind = END_ERR;
        else if (state == S_RDATA && resp_is_error(rresp)) fin.kind = END_ERR;
        else if (state == S_RDATA)                         fin.kind = END_RD_OK;
        else                                               fin.kind = END_WR_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            aw_done <= 1'b0;
            w_done  <= 1'b0;
            cnt     <= '0;
        end else if (state == S_IDLE) begin
            if (start) begin
                addr_q  <= req.addr;
                wdata_q <= req.wdata;
                aw_done <= 1'b0;
                w_done  <= 1'b0;
                cnt     <= '0;
                state   <= req.is_read ? S_RADDR : S_WADDR;
            end
        end else if (tmo) begin
            state <= S_IDLE;
        end else begin
            cnt <= hs ? '0 : cnt + 1'b1;
            case (state)
                S_WADDR: begin
                    if (aw_hs) aw_done <= 1'b1;
                    if (w_hs)  w_done  <= 1'b1;
                    if ((aw_done || aw_hs) && (w_done || w_hs)) state <= S_WRESP;
                end
                S_WRESP: if (bvalid)  state <= S_IDLE;
                S_RADDR: if (arready) state <= S_RDATA;
                default: if (rvalid)  state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/axi_reg_bridge.sv
module axi_reg_bridge
    import axib_pkg::*;
#(
    parameter int INIT_CYCLES    = 16,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq,
    input  logic        ext_irq,
    output logic [31:0] m_awaddr,
    output logic        m_awvalid,
    input  logic        m_awready,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_wstrb,
    output logic        m_wvalid,
    input  logic        m_wready,
    input  logic [1:0]  m_bresp,
    input  logic        m_bvalid,
    output logic        m_bready,
    output logic [31:0] m_araddr,
    output logic        m_arvalid,
    input  logic        m_arready,
    input  logic [31:0] m_rdata,
    input  logic [1:0]  m_rresp,
    input  logic        m_rvalid,
    output logic        m_rready
);
    logic      start, busy, tmo;
    xfer_req_t req;
    xfer_end_t fin;

    axib_regs #(.INIT_CYCLES(INIT_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .fin(fin),
        .ext_irq(ext_irq), .start(start), .req(req), .busy(busy), .irq(irq)
    );

    axib_master #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_master (
        .clk(clk), .rst(rst), .start(start), .req(req), .fin(fin), .tmo(tmo),
        .awaddr(m_awaddr), .awvalid(m_awvalid), .awready(m_awready),
        .wdata(m_wdata), .wstrb(m_wstrb), .wvalid(m_wvalid), .wready(m_wready),
        .bresp(m_bresp), .bvalid(m_bvalid), .bready(m_bready),
        .araddr(m_araddr), .arvalid(m_arvalid), .arready(m_arready),
        .rdata(m_rdata), .rresp(m_rresp), .rvalid(m_rvalid), .rready(m_rready)
    );
endmodule

// File: rtl/axib_chk.sv
module axib_chk (
    input logic        clk,
    input logic        rst,
    input logic        awvalid,
    input logic        awready,
    input logic [31:0] awaddr,
    input logic        wvalid,
    input logic        wready,
    input logic [31:0] wdata,
    input logic        arvalid,
    input logic        arready,
    input logic [31:0] araddr,
    input logic        busy,
    input logic        fin_valid,
    input logic        tmo
);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !fin_valid |=> busy);
    // R3
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        fin_valid |=> !busy);
    // R5
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready && !tmo |=> awvalid && $stable(awaddr));
    // R5
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wready && !tmo |=> wvalid && $stable(wdata));
    // R7
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready && !tmo |=> arvalid && $stable(araddr));
    // R7
    tmo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        tmo |=> !awvalid && !wvalid && !arvalid);
    // R2
    one_channel_chk: assert property (@(posedge clk) disable iff (rst)
        !(arvalid && (awvalid || wvalid)));
endmodule

bind axi_reg_bridge axib_chk u_chk (
    .clk(clk), .rst(rst),
    .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
    .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata),
    .arvalid(m_arvalid), .arready(m_arready), .araddr(m_araddr),
    .busy(busy), .fin_valid(fin.valid), .tmo(tmo)
);

// File: tb/sim_axi_reg_bridge.sv
module sim_axi_reg_bridge;
    localparam int INIT_CYCLES    = 16;
    localparam int TIMEOUT_CYCLES = 1024;

    logic        clk = 1'b0, rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        irq, ext_irq = 1'b0;
    logic [31:0] m_awaddr, m_wdata, m_araddr;
    logic [3:0]  m_wstrb;
    logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic        m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
    logic [1:0]  m_bresp, m_rresp;
    logic [31:0] m_rdata;

    int   n_checks = 0, n_errs = 0;
    bit   finished = 0;
    bit   silent = 0;
    bit   saw_ar = 0;
    logic [31:0] exp_mem [16];

    always #4 clk = ~clk;

    axi_reg_bridge #(.INIT_CYCLES(INIT_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .ext_irq(ext_irq),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    // ---------------- slave model ----------------
    logic [31:0] mem [16];
    logic [31:0] aw_q, w_q;
    logic        got_aw, got_w;
    logic [3:0]  w_strb_q;

    function automatic logic [1:0] resp_for(input logic [31:0] a);
        if (a[31:28] == 4'hE) return 2'b10;
        if (a[31:28] == 4'hD) return 2'b11;
        return 2'b00;
    endfunction

    always @(posedge clk) begin
        if (m_arvalid) saw_ar <= 1'b1;
        if (rst) begin
            m_awready <= 0; m_wready <= 0; m_bvalid <= 0; m_arready <= 0; m_rvalid <= 0;
            m_bresp <= 0; m_rresp <= 0; m_rdata <= 0; got_aw <= 0; got_w <= 0;
            aw_q <= 0; w_q <= 0; w_strb_q <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'd0;
        end else begin
            m_awready <= m_awvalid && !m_awready && !got_aw && !silent && ($urandom % 2 == 0);
            m_wready  <= m_wvalid && !m_wready && !got_w && !silent && ($urandom % 2 == 0);
            m_arready <= m_arvalid && !m_arready && !m_rvalid && !silent && ($urandom % 2 == 0);
            if (m_awvalid && m_awready) begin got_aw <= 1; aw_q <= m_awaddr; end
            if (m_wvalid && m_wready) begin got_w <= 1; w_q <= m_wdata; w_strb_q <= m_wstrb; end
            if (got_aw && got_w && !m_bvalid) begin
                m_bvalid <= 1; m_bresp <= resp_for(aw_q);
                if (resp_for(aw_q) == 2'b00 && w_strb_q == 4'hF) mem[aw_q[5:2]] <= w_q;
                got_aw <= 0; got_w <= 0;
            end
            if (m_bvalid && m_bready) m_bvalid <= 0;
            if (m_arvalid && m_arready) begin
                m_rvalid <= 1; m_rresp <= resp_for(m_araddr); m_rdata <= mem[m_araddr[5:2]];
            end
            if (m_rvalid && m_rready) m_rvalid <= 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] off, input logic [15:0] d);
        @(negedge clk);
        host_we = 1; host_addr = off; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic hrd(input logic [2:0] off, output logic [15:0] d);
        @(negedge clk);
        host_addr = off;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(input int limit);
        logic [15:0] s;
        for (int k = 0; k < limit; k++) begin
            hrd(3'd0, s);
            if (!s[6]) return;
        end
    endtask

    task automatic xfer(input logic [3:0] cmd, input logic [31:0] a, input logic [31:0] d,
                        input logic [4:0] en);
        hwr(3'd0, 16'hF800);
        hwr(3'd2, a[15:0]); hwr(3'd3, a[31:16]);
        hwr(3'd4, d[15:0]); hwr(3'd5, d[31:16]);
        hwr(3'd1, {en, 7'd0, cmd});
        wait_idle(3000);
    endtask

    function automatic logic [15:0] exp_stat(input logic [4:0] ev, input bit avail);
        return {ev, 3'b000, avail, 1'b0, 1'b1, 5'b00000};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        logic [15:0] s, lo, hi;
        void'($urandom(32'd11));
        repeat (5) @(negedge clk);
        rst = 0;
        hrd(3'd0, s);
        chk("R11 init low after reset", {16'd0, s}, 32'h0000);
        chk("R10 irq low after reset", {31'd0, irq}, 32'd0);
        repeat (INIT_CYCLES + 4) @(negedge clk);
        hrd(3'd0, s);
        chk("R11 init done set", {16'd0, s}, 32'h0020);

        // R1 register readback
        hwr(3'd2, 16'hBEEF); hwr(3'd3, 16'h1234); hwr(3'd4, 16'hA5A5); hwr(3'd5, 16'h5A5A);
        hrd(3'd2, s); chk("R1 addr lo", {16'd0, s}, 32'hBEEF);
        hrd(3'd3, s); chk("R1 addr hi", {16'd0, s}, 32'h1234);
        hrd(3'd4, s); chk("R1 wdata lo", {16'd0, s}, 32'hA5A5);
        hrd(3'd5, s); chk("R1 wdata hi", {16'd0, s}, 32'h5A5A);

        // R2 invalid and no-op codes
        hwr(3'd1, 16'h0005); hrd(3'd0, s); chk("R2 code 0x5 no start", {16'd0, s}, 32'h0020);
        hwr(3'd1, 16'h0000); hrd(3'd0, s); chk("R2 code 0x0 no start", {16'd0, s}, 32'h0020);

        // R4 R5 random writes then reads
        for (int i = 0; i < 16; i++) exp_mem[i] = 32'd0;
        for (int n = 0; n < 24; n++) begin
            int idx = $urandom % 16;
            logic [31:0] d = $urandom;
            logic [31:0] a = 32'h0000_0040 + 32'(idx) * 4;
            xfer(4'h8, a, d, 5'd0);
            exp_mem[idx] = d;
            hrd(3'd0, s); chk("R4 write done event", {16'd0, s}, {16'd0, exp_stat(5'b01000, 0)});
            idx = $urandom % 16;
            a = 32'h0000_0040 + 32'(idx) * 4;
            xfer(4'hA, a, 32'd0, 5'd0);
            hrd(3'd0, s); chk("R4 read done event", {16'd0, s}, {16'd0, exp_stat(5'b10000, 1)});
            hrd(3'd6, lo); hrd(3'd7, hi);
            chk("R5 R4 read data", {hi, lo}, exp_mem[idx]);
        end

        // R6 errors
        xfer(4'h8, 32'hE000_0040, 32'h1111_2222, 5'd0);
        hrd(3'd0, s); chk("R6 SLVERR write", {16'd0, s}, {16'd0, exp_stat(5'b00010, 0)});
        xfer(4'hA, 32'hD000_0044, 32'd0, 5'd0);
        hrd(3'd0, s); chk("R6 DECERR read", {16'd0, s}, {16'd0, exp_stat(5'b00010, 0)});
        xfer(4'h9, 32'hE000_0040, 32'd0, 5'd0);
        hrd(3'd2, lo); hrd(3'd3, hi);
        chk("R8 no increment on error", {hi, lo}, 32'hE000_0040);

        // R8 post-increment with carry
        xfer(4'h9, 32'h0000_FFFC, 32'hCAFE_F00D, 5'd0);
        exp_mem[15] = 32'hCAFE_F00D;
        hrd(3'd2, lo); hrd(3'd3, hi);
        chk("R8 increment carry", {hi, lo}, 32'h0001_0000);
        hwr(3'd1, 16'h000B); wait_idle(3000);
        hrd(3'd6, lo); hrd(3'd7, hi);
        chk("R8 read at incremented addr", {hi, lo}, exp_mem[0]);
        hrd(3'd2, lo); hrd(3'd3, hi);
        chk("R8 second increment", {hi, lo}, 32'h0001_0004);

        // R9 write-one-to-clear and live bits
        xfer(4'h8, 32'h0000_0040, 32'h7, 5'd0);
        hwr(3'd0, 16'h0000); hrd(3'd0, s); chk("R9 zero keeps event", {16'd0, s}, {16'd0, exp_stat(5'b01000, 0)});
        hwr(3'd0, 16'h00E0); hrd(3'd0, s); chk("R9 live bits ignore write", {16'd0, s}, {16'd0, exp_stat(5'b01000, 0)});
        hwr(3'd0, 16'h4000); hrd(3'd0, s); chk("R9 one clears event", {16'd0, s}, 32'h0020);

        // R10 interrupt gating
        xfer(4'h8, 32'h0000_0044, 32'h9, 5'b01000);
        @(negedge clk); chk("R10 irq enabled", {31'd0, irq}, 32'd1);
        hwr(3'd0, 16'h4000); @(negedge clk); chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        xfer(4'h8, 32'h0000_0044, 32'h9, 5'b10000);
        @(negedge clk); chk("R10 irq not enabled", {31'd0, irq}, 32'd0);

        // R12 external interrupt
        hwr(3'd0, 16'hF800);
        @(negedge clk); ext_irq = 1; @(negedge clk); ext_irq = 0;
        hrd(3'd0, s); chk("R12 ext irq event", {16'd0, s}, {16'd0, exp_stat(5'b00001, 0)});
        hwr(3'd0, 16'h0800); hrd(3'd0, s); chk("R12 ext irq cleared", {16'd0, s}, 32'h0020);

        // R3 R7 timeout with command while busy
        silent = 1;
        hwr(3'd0, 16'hF800);
        hwr(3'd1, 16'h0008);
        @(negedge clk); saw_ar = 0;
        hwr(3'd1, 16'h000A);
        hrd(3'd0, s); chk("R3 busy while pending", {31'd0, s[6]}, 32'd1);
        repeat (TIMEOUT_CYCLES - 40) @(negedge clk);
        hrd(3'd0, s); chk("R7 still busy before limit", {31'd0, s[6]}, 32'd1);
        repeat (60) @(negedge clk);
        hrd(3'd0, s); chk("R7 timeout event only", {16'd0, s}, {16'd0, exp_stat(5'b00100, 0)});
        chk("R3 command while busy ignored", {31'd0, saw_ar}, 32'd0);
        chk("R7 valids dropped", {30'd0, m_awvalid, m_wvalid}, 32'd0);
        silent = 0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule